// File: doc/BRIEF.md
# Powered-Device Detect Status Controller

This block holds the register-visible state that tells management software whether the attached link partner is asking for power. A raw detection level comes in as a single synchronous input. While detection is armed, the block sets a status bit as soon as that level is seen. When the level goes away, the status bit is held high for a programmable hold-off before it drops. A sticky change flag records every transition of the status bit.

Configuration arrives through a one-cycle write strobe. Each strobe carries both the requested arm bit and a 4-bit drop-delay field. The drop delay takes effect at once. The requested arm bit is only stored until a software reset copies it into the active arm bit. A hardware reset returns every field to its default. A software reset clears the status and change bits, keeps the configuration, and promotes the stored arm request.

The hold-off is measured in units of nominally five seconds. Each unit is `TICKS_PER_UNIT` pulses of a slow time-base tick. The parameter lets a short unit be chosen for simulation.

Top module: `pd_detect_status`

## Requirements
- R1: After hardware reset (`rst` high), `en_pending` = 0, `en_active` = 0, `drop_delay` = 4, `pd_status` = 0 and `pd_changed` = 0.
- R2: A write (`cfg_wr` high) loads `cfg_wr_enable` into `en_pending` at that edge. `en_active` changes only at an edge where `sw_rst` is high, and it then takes the `en_pending` value held before that edge.
- R3: At an edge with `sw_rst` high, `pd_status` and `pd_changed` go to 0, while `drop_delay` and `en_pending` keep their values.
- R4: While `en_active` is 1, an edge that samples `partner_det` = 1 sets `pd_status` to 1.
- R5: While `en_active` is 0, `pd_status` stays 0 whatever `partner_det` does.
- R6: Once `partner_det` falls while `pd_status` is 1, the status clears at the edge that samples the (N×TICKS_PER_UNIT)-th high `tick`. The count includes the edge where the loss is first seen, and N is `drop_delay`. Edges with `tick` low do not advance the hold-off.
- R7: With N = 0, `pd_status` clears at the first edge that samples `partner_det` = 0.
- R8: If `partner_det` returns during the hold-off, `pd_status` stays 1 and a later loss starts a full new hold-off.
- R9: Every change of `pd_status` other than one caused by a reset sets `pd_changed`. The flag stays set until an edge with `stat_rd` high clears it. If a status change and a read fall on the same edge, the flag stays set.
- R10: A write loads `cfg_wr_drop` into `drop_delay` at that edge, with no software reset needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| sw_rst | input | 1 | Software reset pulse |
| tick | input | 1 | Slow time-base pulse |
| partner_det | input | 1 | Raw partner-detected level |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wr_enable | input | 1 | Requested arm bit carried by a write |
| cfg_wr_drop | input | 4 | Drop-delay field carried by a write |
| stat_rd | input | 1 | Status register read strobe |
| en_pending | output | 1 | Stored arm request |
| en_active | output | 1 | Arm bit in force |
| drop_delay | output | 4 | Hold-off length in units |
| pd_status | output | 1 | 1 = partner needs power |
| pd_changed | output | 1 | Sticky status-change flag |

## Verification
The hold-off is swept over all sixteen drop-delay values under two tick patterns. With a tick on every cycle, the fall time is exactly N×TICKS_PER_UNIT. With a tick on alternate cycles, the fall time becomes 2·N·TICKS_PER_UNIT−1. Together the two patterns separate counting ticks from counting clock cycles, and they expose any off-by-one at the unit wrap. A loss shorter than the hold-off followed by a return checks that the timer restarts rather than resumes. A run with the tick held low checks that clock cycles alone never expire it. Separate sequences cover the arm request before and after a software reset, detection while disarmed, and a read that lands on the same edge as a status change.

// File: rtl/pdd_pkg.sv
package pdd_pkg;
  localparam int unsigned DROP_W = 4;
  localparam logic [DROP_W-1:0] DROP_HW_DEFAULT = 4'd4;

  typedef struct packed {
    logic              arm;
    logic [DROP_W-1:0] drop;
  } pdd_cfg_t;
endpackage

// File: rtl/pdd_cfg_regs.sv
module pdd_cfg_regs
  import pdd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic              wr,
  input  pdd_cfg_t          wr_data,
  output logic              arm_pending,
  output logic              arm_active,
  output logic [DROP_W-1:0] drop
);
  pdd_cfg_t cfg_q;
  logic     active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.arm  <= 1'b0;
      cfg_q.drop <= DROP_HW_DEFAULT;
      active_q   <= 1'b0;
    end else begin
      if (sw_rst) active_q <= cfg_q.arm;
      if (wr)     cfg_q    <= wr_data;
    end
  end

  assign arm_pending = cfg_q.arm;
  assign arm_active  = active_q;
  assign drop        = cfg_q.drop;

  // R2: the arm bit in force moves only at a software reset
  p_active_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !sw_rst |=> arm_active == $past(arm_active));
  // R2: a software reset promotes the stored request
  p_active_load_r2: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> arm_active == $past(arm_pending));
  // R3: a software reset without a write keeps the configuration
  p_cfg_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (sw_rst && !wr) |=> $stable(drop) && $stable(arm_pending));
endmodule

// File: rtl/pdd_holdoff_timer.sv
module pdd_holdoff_timer #(
  parameter int unsigned TICKS_PER_UNIT = 5000,
  parameter int unsigned DW             = 4
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          run,
  input  logic          tick,
  input  logic [DW-1:0] drop,
  output logic          expire
);
  localparam int unsigned PW = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICKS_PER_UNIT - 1);

  logic [PW-1:0] pre_q;
  logic [DW-1:0] unit_q;
  logic          unit_wrap;
  logic          last_unit;

  assign unit_wrap = tick && (pre_q == PRE_LAST);
  // tolerate drop being lowered below the units already counted
  assign last_unit = ({1'b0, unit_q} + 1'b1) >= {1'b0, drop};
  assign expire    = run && ((drop == '0) || (unit_wrap && last_unit));

  always_ff @(posedge clk) begin
    if (clr || !run || expire) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else if (tick) begin
      if (unit_wrap) begin
        pre_q  <= '0;
        unit_q <= unit_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R6: the prescaler never passes its last value
  p_pre_bound_r6: assert property (@(posedge clk) disable iff (clr)
    pre_q <= PRE_LAST);
  // R6: no progress while the time base is quiet
  p_no_tick_hold_r6: assert property (@(posedge clk) disable iff (clr)
    (run && !tick && !expire) |=> run |-> ($stable(pre_q) && $stable(unit_q)));
endmodule

// File: rtl/pdd_status_ctrl.sv
module pdd_status_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic sw_rst,
  input  logic arm,
  input  logic det,
  input  logic expire,
  input  logic rd,
  output logic run,
  output logic status,
  output logic changed
);
  logic status_q, changed_q, status_nxt;

  assign run = arm && !det && status_q;

  always_comb begin
    status_nxt = status_q;
    if (!arm)        status_nxt = 1'b0;
    else if (det)    status_nxt = 1'b1;
    else if (expire) status_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || sw_rst) begin
      status_q  <= 1'b0;
      changed_q <= 1'b0;
    end else begin
      status_q <= status_nxt;
      if (status_nxt != status_q) changed_q <= 1'b1;
      else if (rd)                changed_q <= 1'b0;
    end
  end

  assign status  = status_q;
  assign changed = changed_q;

  // R5: disarmed means no power request
  p_disarmed_low_r5: assert property (@(posedge clk) disable iff (rst)
    !arm |-> !status);
  // R4: detection while armed raises status
  p_rise_on_det_r4: assert property (@(posedge clk) disable iff (rst)
    (arm && det && !sw_rst) |=> status);
  // R3: software reset clears status and flag
  p_swrst_clear_r3: assert property (@(posedge clk) disable iff (rst)
    sw_rst |=> (!status && !changed));
  // R9: a status change not caused by reset leaves the flag set
  p_flag_on_change_r9: assert property (@(posedge clk) disable iff (rst)
    (!sw_rst && (status_nxt != status)) |=> changed);
  // R8: detection present keeps status high
  p_hold_while_det_r8: assert property (@(posedge clk) disable iff (rst)
    (status && arm && det && !sw_rst) |=> status);
endmodule

// File: rtl/pd_detect_status.sv
module pd_detect_status
  import pdd_pkg::*;
#(
  parameter int unsigned TICKS_PER_UNIT = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_rst,
  input  logic              tick,
  input  logic              partner_det,
  input  logic              cfg_wr,
  input  logic              cfg_wr_enable,
  input  logic [DROP_W-1:0] cfg_wr_drop,
  input  logic              stat_rd,
  output logic              en_pending,
  output logic              en_active,
  output logic [DROP_W-1:0] drop_delay,
  output logic              pd_status,
  output logic              pd_changed
);
  pdd_cfg_t wr_data;
  logic     run, expire;

  assign wr_data.arm  = cfg_wr_enable;
  assign wr_data.drop = cfg_wr_drop;

  pdd_cfg_regs u_cfg (
    .clk         (clk),
    .rst         (rst),
    .sw_rst      (sw_rst),
    .wr          (cfg_wr),
    .wr_data     (wr_data),
    .arm_pending (en_pending),
    .arm_active  (en_active),
    .drop        (drop_delay)
  );

  pdd_holdoff_timer #(
    .TICKS_PER_UNIT (TICKS_PER_UNIT),
    .DW             (DROP_W)
  ) u_timer (
    .clk    (clk),
    .clr    (rst || sw_rst),
    .run    (run),
    .tick   (tick),
    .drop   (drop_delay),
    .expire (expire)
  );

  pdd_status_ctrl u_stat (
    .clk     (clk),
    .rst     (rst),
    .sw_rst  (sw_rst),
    .arm     (en_active),
    .det     (partner_det),
    .expire  (expire),
    .rd      (stat_rd),
    .run     (run),
    .status  (pd_status),
    .changed (pd_changed)
  );

  // R7: zero delay drops status on the first missing sample
  p_zero_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (en_active && pd_status && !partner_det && drop_delay == '0 && !sw_rst) |=> !pd_status);
endmodule

// File: tb/pd_detect_status_test.sv
module pd_detect_status_test;
  localparam int TPU = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1, sw_rst = 1'b0, tick = 1'b0, partner_det = 1'b0;
  logic       cfg_wr = 1'b0, cfg_wr_enable = 1'b0, stat_rd = 1'b0;
  logic [3:0] cfg_wr_drop = 4'd0;
  logic       en_pending, en_active, pd_status, pd_changed;
  logic [3:0] drop_delay;

  int n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  pd_detect_status #(.TICKS_PER_UNIT(TPU)) uut (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .tick(tick), .partner_det(partner_det),
    .cfg_wr(cfg_wr), .cfg_wr_enable(cfg_wr_enable), .cfg_wr_drop(cfg_wr_drop),
    .stat_rd(stat_rd), .en_pending(en_pending), .en_active(en_active),
    .drop_delay(drop_delay), .pd_status(pd_status), .pd_changed(pd_changed));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d exp=<50000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic en, input logic [3:0] d);
    cfg_wr = 1'b1; cfg_wr_enable = en; cfg_wr_drop = d;
    step();
    cfg_wr = 1'b0;
  endtask

  task automatic swr();
    sw_rst = 1'b1;
    step();
    sw_rst = 1'b0;
  endtask

  // raise status, clear flag, then drop detection and time the fall
  task automatic measure(input int n, input int pat, input int exp, input string tag);
    int cnt = 0;
    tick = 1'b0; partner_det = 1'b1;
    step();
    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
    partner_det = 1'b0;
    for (int k = 0; k < 400; k++) begin
      tick = (pat == 0) ? 1'b1 : (k % 2 == 0);
      step();
      cnt++;
      if (!pd_status) break;
    end
    chk($sformatf("%s N=%0d pat=%0d fall", tag, n, pat), cnt, exp);
    chk($sformatf("R9 N=%0d pat=%0d flag", n, pat), pd_changed, 1);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    // R1 reset state
    chk("R1 en_pending", en_pending, 0);
    chk("R1 en_active", en_active, 0);
    chk("R1 drop", drop_delay, 4);
    chk("R1 status", pd_status, 0);
    chk("R1 changed", pd_changed, 0);

    // R5 detection while disarmed
    partner_det = 1'b1;
    repeat (3) step();
    chk("R5 disarmed status", pd_status, 0);

    // R2 / R10 write without software reset
    wr(1'b1, 4'd9);
    chk("R2 pending", en_pending, 1);
    chk("R2 active unchanged", en_active, 0);
    chk("R10 drop", drop_delay, 9);
    step();
    chk("R5 still disarmed", pd_status, 0);

    swr();
    chk("R2 active promoted", en_active, 1);
    chk("R3 drop kept", drop_delay, 9);
    step();
    chk("R4 rise", pd_status, 1);
    chk("R9 set on rise", pd_changed, 1);

    stat_rd = 1'b1;
    step();
    stat_rd = 1'b0;
    chk("R9 read clears", pd_changed, 0);

    // R3 software reset while requesting power
    step();
    swr();
    chk("R3 status cleared", pd_status, 0);
    chk("R3 flag cleared", pd_changed, 0);
    chk("R3 pending kept", en_pending, 1);
    chk("R3 drop kept", drop_delay, 9);
    step();
    chk("R4 rise again", pd_status, 1);

    // R7 + R9 read on the same edge as the fall
    wr(1'b1, 4'd0);
    stat_rd = 1'b1; partner_det = 1'b0;
    step();
    stat_rd = 1'b0;
    chk("R7 immediate fall", pd_status, 0);
    chk("R9 set beats read", pd_changed, 1);

    // R6 / R7 sweep over every delay and two tick patterns
    for (int n = 0; n < 16; n++) begin
      for (int pat = 0; pat < 2; pat++) begin
        int e;
        wr(1'b1, 4'(n));
        if (n == 0) e = 1;
        else if (pat == 0) e = n * TPU;
        else e = 2 * n * TPU - 1;
        measure(n, pat, e, (n == 0) ? "R7" : "R6");
      end
    end

    // R8 return during hold-off cancels it
    wr(1'b1, 4'd2);
    tick = 1'b1; partner_det = 1'b1;
    step();
    partner_det = 1'b0;
    repeat (4) step();
    chk("R8 still high mid hold-off", pd_status, 1);
    partner_det = 1'b1;
    step();
    chk("R8 held on return", pd_status, 1);
    measure(2, 0, 2 * TPU, "R8");

    // R6 no tick, no progress
    wr(1'b1, 4'd1);
    tick = 1'b0; partner_det = 1'b1;
    step();
    partner_det = 1'b0;
    repeat (20) step();
    chk("R6 quiet time base", pd_status, 1);

    // R5 disarm through software reset
    wr(1'b0, 4'd4);
    swr();
    chk("R2 active off", en_active, 0);
    partner_det = 1'b1;
    repeat (5) step();
    chk("R5 disarmed again", pd_status, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule